// File: doc/BRIEF.md
# Background SRAM Slice March Tester

This block checks a large single-port synchronous SRAM for developing faults while the rest of the system keeps using it. It takes the memory one slice at a time. For each slice it reads the live contents into an internal holding buffer and runs a March sequence over the slice. It then writes the held contents back, so the system sees the same data afterwards. The slice base then moves on by one slice. When the last slice of the memory is done, the base wraps to zero and a one-cycle pass pulse marks a clean sweep.

The system asks for the memory with a request line. It is granted only while the tester sits between slices. Once a slice has started, the tester keeps the memory until that slice is restored. An interval counter runs while the tester is enabled and restarts at every completed sweep. If the counter expires first, a sticky timeout flag is raised. Ordinary system reads are not checked. Faults are only caught by the background sweep.

Top module: `sram_slice_march`

## Requirements
- R1: A slice begins with SLICE reads at the slice's addresses in ascending order (base+0 first), issued on consecutive cycles, before any write to the slice.
- R2: After a fault-free sweep, every memory word holds the value it held before the sweep, including values the system wrote while it held the grant.
- R3: Every tester access falls inside the current slice. The tester stays busy for exactly (2+N)*SLICE cycles per slice, where N is 13 or 7.
- R4: With mode_short=0 the test is the 13-operation sequence w0; up(r0,w1,r1); up(r1,w0,r0); down(r0,w1,r1); down(r1,w0,r0), using all-zero and all-one words. With mode_short=1 the two middle elements are skipped (7 operations). The first write of a slice stores all zeros at base+0.
- R5: A read that differs from the expected word sets err, which stays set until reset. err_addr holds the address of the first mismatching read and stays stable afterwards.
- R6: A slice with an error is still fully restored. The tester then starts no further slice (busy stays low), and words outside the faulty cell keep their values.
- R7: sys_gnt is high only while sys_req is high and busy is low. A slice starts only in a cycle where sys_req is low, and once started it runs to its end without yielding.
- R8: The slice base advances by SLICE after each slice and wraps to zero after the top slice. Finishing the top slice with err low gives a one-cycle pass_pulse.
- R9: If enable has been high for more than INTERVAL cycles since reset or since the last completed sweep, timeout is set and stays set until reset.
- R10: With enable low, the tester performs no memory access.
- R11: During and directly after reset, busy, err, pass_pulse, timeout, mem_en and sys_gnt (with sys_req low) are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows the tester to start slices |
| mode_short | input | 1 | 1 selects the 7-operation March, 0 the 13-operation one; sampled at slice start |
| sys_req | input | 1 | System request for the memory |
| sys_gnt | output | 1 | Memory granted to the system |
| mem_en | output | 1 | Tester memory access enable |
| mem_we | output | 1 | Tester write strobe |
| mem_addr | output | ADDR_W | Tester address |
| mem_wdata | output | DATA_W | Tester write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read |
| busy | output | 1 | A slice is being saved, tested or restored |
| err | output | 1 | Sticky mismatch flag |
| err_addr | output | ADDR_W | Address of the first mismatch |
| pass_pulse | output | 1 | One-cycle pulse at the end of a clean sweep |
| timeout | output | 1 | Sticky flag: sweep not finished within INTERVAL |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the read. They also assume that only the tester drives the memory while busy is high, with the outside mux following busy and sys_gnt. The bench model meets both: its memory port is switched by busy, and system accesses are issued only in cycles where sys_gnt is seen high. Faults are injected only into a single cell, and only after that cell has been filled through the system port. This keeps the first-mismatch address well defined.

// File: rtl/sram_slice_march.sv
module sram_slice_march #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int SLICE    = 16,
  parameter int INTERVAL = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_short,
  input  logic              sys_req,
  output logic              sys_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr,
  output logic              pass_pulse,
  output logic              timeout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SL_W  = $clog2(SLICE);
  localparam int IV_W  = $clog2(INTERVAL + 1);
  localparam logic [ADDR_W-1:0] LAST_BASE = ADDR_W'(DEPTH - SLICE);
  localparam logic [SL_W-1:0]   IDX_MAX   = SL_W'(SLICE - 1);

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_MARCH, S_REST} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base;
  logic [SL_W-1:0]   idx;
  logic [2:0]        elem;
  logic [1:0]        op;
  logic              short_q;
  logic [DATA_W-1:0] save_q [SLICE];
  logic              rd_pend, rd_save, rd_bit;
  logic [SL_W-1:0]   rd_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic [IV_W-1:0]   iv_cnt;

  // element 0 is a lone write; odd elements start from 0, even ones from 1
  wire op_read   = (elem != 3'd0) && (op != 2'd1);
  wire op_bit    = (elem == 3'd0) ? 1'b0 : ((op == 2'd0) ? ~elem[0] : elem[0]);
  wire op_last   = (elem == 3'd0) || (op == 2'd2);
  wire desc      = elem >= 3'd3;
  wire slice_end = idx == IDX_MAX;
  wire sweep_end = (st == S_REST) && slice_end && (base == LAST_BASE);
  wire [2:0] elem_nx = (elem == 3'd1 && short_q) ? 3'd4 : elem + 3'd1;
  wire [SL_W-1:0] off = (st == S_MARCH && desc) ? ~idx : idx;
  wire rd_bad    = rd_pend && !rd_save && (mem_rdata != {DATA_W{rd_bit}});

  assign busy      = st != S_IDLE;
  assign sys_gnt   = sys_req && !busy;
  assign mem_en    = busy;
  assign mem_we    = (st == S_REST) || (st == S_MARCH && !op_read);
  assign mem_addr  = base + ADDR_W'(off);
  assign mem_wdata = (st == S_REST) ? save_q[idx] : {DATA_W{op_bit}};

  always_ff @(posedge clk) begin
    if (rd_pend && rd_save) save_q[rd_idx] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; idx <= '0; elem <= '0; op <= '0; short_q <= 1'b0;
      rd_pend <= 1'b0; rd_save <= 1'b0; rd_bit <= 1'b0; rd_idx <= '0; rd_addr <= '0;
      err <= 1'b0; err_addr <= '0; pass_pulse <= 1'b0; timeout <= 1'b0; iv_cnt <= '0;
    end else begin
      pass_pulse <= 1'b0;
      rd_pend    <= mem_en && !mem_we;
      rd_save    <= st == S_SAVE;
      rd_bit     <= op_bit;
      rd_idx     <= idx;
      rd_addr    <= mem_addr;
      if (rd_bad && !err) begin
        err      <= 1'b1;
        err_addr <= rd_addr;
      end
      if (sweep_end) iv_cnt <= '0;
      else if (enable && iv_cnt != IV_W'(INTERVAL)) iv_cnt <= iv_cnt + IV_W'(1);
      if (iv_cnt == IV_W'(INTERVAL)) timeout <= 1'b1;
      case (st)
        S_IDLE: if (enable && !sys_req && !err) begin
          st <= S_SAVE; idx <= '0; elem <= '0; op <= '0; short_q <= mode_short;
        end
        S_SAVE: begin
          idx <= idx + SL_W'(1);
          if (slice_end) st <= S_MARCH;
        end
        S_MARCH: begin
          if (op_last) begin
            op  <= '0;
            idx <= idx + SL_W'(1);
            if (slice_end) begin
              if (elem == 3'd4) st <= S_REST;
              else elem <= elem_nx;
            end
          end else begin
            op <= op + 2'd1;
          end
        end
        default: begin
          idx <= idx + SL_W'(1);
          if (slice_end) begin
            st   <= S_IDLE;
            base <= base + ADDR_W'(SLICE);
            if (base == LAST_BASE) pass_pulse <= !err && !rd_bad;
          end
        end
      endcase
    end
  end

  AST_ADDR_IN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (ADDR_W'(mem_addr - base) <= ADDR_W'(SLICE - 1)));                // R3
  AST_NO_MIDSLICE_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(st == S_REST && slice_end)) |=> busy);                           // R7
  AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable && !sys_req && !err));                         // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && $stable(err_addr)));                                        // R5
  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |=> !pass_pulse);                                                // R8
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (base & ADDR_W'(SLICE - 1)) == '0);                                         // R8
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);                                                       // R9
endmodule

// File: tb/sram_slice_march_tb_top.sv
`timescale 1ns/1ps
module sram_slice_march_tb_top;
  localparam int AW = 8, DW = 16, SL = 16, IV = 8192, DEP = 256;

  logic clk = 0, rst_n = 0, enable = 0, mode_short = 0, sys_req = 0;
  logic sys_gnt, t_en, t_we, busy, err, pass_pulse, timeout;
  logic [AW-1:0] t_addr, err_addr;
  logic [DW-1:0] t_wd, m_rdata;
  logic s_en = 0, s_we = 0;
  logic [AW-1:0] s_addr = '0;
  logic [DW-1:0] s_wd = '0;
  int f_type = 0, f_addr = 0, f_bit = 0;
  logic [DW-1:0] mem [DEP];
  logic [DW-1:0] golden [DEP];
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  sram_slice_march #(.ADDR_W(AW), .DATA_W(DW), .SLICE(SL), .INTERVAL(IV)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_short(mode_short),
    .sys_req(sys_req), .sys_gnt(sys_gnt), .mem_en(t_en), .mem_we(t_we),
    .mem_addr(t_addr), .mem_wdata(t_wd), .mem_rdata(m_rdata), .busy(busy),
    .err(err), .err_addr(err_addr), .pass_pulse(pass_pulse), .timeout(timeout));

  wire          m_en   = busy ? t_en : (sys_gnt & s_en);
  wire          m_we   = busy ? t_we : s_we;
  wire [AW-1:0] m_addr = busy ? t_addr : s_addr;
  wire [DW-1:0] m_wd   = busy ? t_wd : s_wd;

  function automatic logic [DW-1:0] wr_val(input int a, input logic [DW-1:0] nv, input logic [DW-1:0] ov);
    logic [DW-1:0] v = nv;
    if (f_type == 3 && a == f_addr && !ov[f_bit] && nv[f_bit]) v[f_bit] = 1'b0;
    return v;
  endfunction
  function automatic logic [DW-1:0] rd_val(input int a, input logic [DW-1:0] ov);
    logic [DW-1:0] v = ov;
    if (f_type == 1 && a == f_addr) v[f_bit] = 1'b0;
    if (f_type == 2 && a == f_addr) v[f_bit] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_en) begin
      if (m_we) mem[m_addr] <= wr_val(int'(m_addr), m_wd, mem[m_addr]);
      m_rdata <= rd_val(int'(m_addr), mem[m_addr]);
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 0; enable = 0; sys_req = 0; f_type = 0;
    repeat (3) tick();
    rst_n = 1; tick();
  endtask

  task automatic fill(input int seed);
    sys_req = 1;
    while (!sys_gnt) tick();
    for (int i = 0; i < DEP; i++) begin
      s_en = 1; s_we = 1; s_addr = AW'(i); s_wd = DW'(i * 40503 + seed * 7919) ^ 16'h5A3C;
      tick();
    end
    s_en = 0; s_we = 0; sys_req = 0;
    for (int i = 0; i < DEP; i++) golden[i] = mem[i];
  endtask

  function automatic int diffs(input int skip);
    int n = 0;
    for (int i = 0; i < DEP; i++) if (i != skip && mem[i] !== golden[i]) n++;
    return n;
  endfunction

  // ftype(0 none,1 stuck0,2 stuck1,3 rise blocked), addr, bit, mode, expected err
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 8'd0,   8'd0,  4'd0, 4'd0},
    {8'd0, 8'd0,   8'd0,  4'd1, 4'd0},
    {8'd2, 8'd5,   8'd0,  4'd0, 4'd1},
    {8'd1, 8'd200, 8'd15, 4'd1, 4'd1},
    {8'd3, 8'd77,  8'd3,  4'd0, 4'd1},
    {8'd3, 8'd255, 8'd7,  4'd1, 4'd1},
    {8'd2, 8'd16,  8'd1,  4'd1, 4'd1}
  };

  initial begin : watchdog
    wait (cyc > 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int n, seen, lim;
    repeat (3) tick();
    // R11 reset state
    chk(!busy && !err && !pass_pulse && !timeout && !t_en && !sys_gnt, "R11 reset outputs",
        {busy, err, pass_pulse, timeout, t_en, sys_gnt}, 0);
    rst_n = 1; tick();
    chk(!busy && !err && !t_en && !sys_gnt, "R11 after reset", {busy, err, t_en, sys_gnt}, 0);
    // R10 enable low: no access
    n = 0;
    repeat (50) begin if (t_en) n++; tick(); end
    chk(n == 0, "R10 no access while disabled", n, 0);
    sys_req = 1; tick();
    chk(sys_gnt, "R7 grant when idle", sys_gnt, 1);
    sys_req = 0;

    // table of fault scenarios
    for (int v = 0; v < NV; v++) begin
      do_reset();
      fill(v + 1);
      f_type = int'(VEC[v][31:24]); f_addr = int'(VEC[v][23:16]); f_bit = int'(VEC[v][15:8]);
      mode_short = VEC[v][4]; enable = 1;
      seen = 0; lim = 0;
      while (!(pass_pulse || (err && !busy)) && lim < 20000) begin tick(); lim++; end
      seen = pass_pulse;
      enable = 0;
      repeat (4) tick();
      if (VEC[v][0]) begin
        chk(err, "R5 fault detected", err, 1);
        chk(int'(err_addr) == f_addr, "R5 first failing address", err_addr, f_addr);
        chk(!busy, "R6 tester halted after error", busy, 0);
        n = diffs(f_addr);
        chk(n == 0, "R6 slice restored after error", n, 0);
      end else begin
        chk(!err && seen == 1, "R8 clean sweep pass pulse", {err, seen[0]}, 1);
        n = diffs(-1);
        chk(n == 0, "R2 contents unchanged after sweep", n, 0);
      end
    end

    // R1 / R3 / R4 / R8 directed slice timing and order
    do_reset(); fill(11);
    mode_short = 0; enable = 1;
    while (!busy) tick();
    n = 0; seen = 0;
    while (busy) begin
      if (n < SL && !(t_en && !t_we && int'(t_addr) == n)) seen++;
      if (n == SL) chk(t_we && t_addr == 0 && t_wd == 0, "R4 first write is zero at base", {t_we, t_addr, t_wd}, 1 << 24);
      n++; tick();
    end
    chk(seen == 0, "R1 save reads ascending", seen, 0);
    chk(n == 15 * SL, "R3 busy length 13-op", n, 15 * SL);
    mode_short = 1;
    while (!busy) tick();
    chk(t_addr == AW'(SL) && !t_we, "R8 base advanced", t_addr, SL);
    n = 0;
    while (busy) begin n++; tick(); end
    chk(n == 9 * SL, "R4 busy length 7-op", n, 9 * SL);
    seen = 0; lim = 0;
    while (seen < 2 && lim < 9000) begin if (pass_pulse) seen++; tick(); lim++; end
    chk(seen == 2, "R8 wrap and second sweep", seen, 2);
    chk(!timeout, "R9 no timeout on timely sweeps", timeout, 0);
    enable = 0; repeat (300) tick();

    // R7 yield only at slice boundary, R2 system write kept
    do_reset(); fill(12);
    mode_short = 1; enable = 1;
    while (!busy) tick();
    repeat (20) tick();
    sys_req = 1; seen = 0;
    while (busy) begin if (sys_gnt) seen++; tick(); end
    chk(seen == 0, "R7 no grant mid-slice", seen, 0);
    chk(sys_gnt, "R7 grant at slice boundary", sys_gnt, 1);
    s_en = 1; s_we = 1; s_addr = 8'd100; s_wd = 16'hBEEF; tick();
    s_en = 0; s_we = 0; golden[100] = 16'hBEEF;
    n = 0;
    repeat (100) begin if (busy) n++; tick(); end
    chk(n == 0, "R7 no slice while requested", n, 0);
    sys_req = 0; lim = 0;
    while (!pass_pulse && lim < 6000) begin tick(); lim++; end
    enable = 0; repeat (2) tick();
    n = diffs(-1);
    chk(n == 0, "R2 system write preserved", n, 0);

    // R9 timeout when starved
    do_reset();
    enable = 1; sys_req = 1;
    repeat (IV - 10) tick();
    chk(!timeout, "R9 no early timeout", timeout, 0);
    repeat (20) tick();
    chk(timeout, "R9 timeout raised", timeout, 1);
    enable = 0; sys_req = 0; repeat (5) tick();
    chk(timeout, "R9 timeout sticky", timeout, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule